// File: doc/BRIEF.md
# Interleaved Flash Query Read Responder

This block supplies read data for a bank of identical parallel NOR flash devices that share one data bus. It tracks which command mode the bank is in (array read, identification read, common-flash-interface query or status polling) and answers each read accordingly. For identification and query reads it converts the bus byte offset into the index a single device expects, looks the answer up in small internal tables, and copies that per-device answer into every device lane of the bank. The index is scaled so that devices able to run wider than they are wired still answer correctly when several of them are interleaved in byte mode across a wider bank.

Reads arrive on a valid/ready request channel and leave on a valid/ready response channel with a single response register. A request is taken only when the response register is empty or is being drained in the same cycle; a response stays on the bus, unchanged, until the consumer raises `rsp_ready`. Array data comes from a simple combinational memory port addressed by the request offset. A read may be wider than the bank; it is then built from consecutive bank-wide answers at rising offsets. A maximum device width of zero means the devices run at their full width.

Top module: `flash_query_resp`

## Requirements
- R1: After reset no response is pending, `rd_ready` is 1, the mode is array read and the status byte is 0x80.
- R2: An accepted command code sets the mode: 0x90 identification, 0x98 query, 0xA0, 0x10 or 0x30 status, 0x00 or 0x80 array read; any other code leaves the mode unchanged.
- R3: A request accepted at a clock edge gives `rsp_valid` high after that edge; while `rsp_valid` is high and `rsp_ready` low, `rsp_data` holds and `rd_ready` is 0.
- R4: In array mode `mem_addr` equals `rd_ofs` and the response equals `mem_rdata`.
- R5: Bank-wide part k (k = 0 .. RD_BYTES/BANK_BYTES-1, occupying bytes k*BANK_BYTES upward) uses index (rd_ofs + k*BANK_BYTES) >> (log2 BANK_BYTES + log2 max width − log2 DEV_BYTES); defaults give shift 3.
- R6: In identification mode, index low byte 0 gives the manufacturer code, 1 the device code, 2 gives zero; the low DEV_BYTES bytes of that value are repeated in every device lane; index bits above 7 are ignored.
- R7: In identification mode, index low byte 0x0E gives extended word 2 and 0x0F extended word 3 (lane-repeated as in R6); when that word is 0xFFFF, or for any other index, part k is bytes k*BANK_BYTES upward of `mem_rdata`.
- R8: In query mode, index i below CFI_LEN (64) gives table byte: 0x51, 0x52, 0x59, 0x02 for i = 0x10..0x13, otherwise i XOR 0xA5; an index of CFI_LEN or more gives zero.
- R9: With devices narrowed to byte mode, the query byte fills every byte of the bank part, not zero-padded; a narrowed setup with devices wider than one byte answers zero.
- R10: A status read returns the status byte in every response byte, and each accepted status read then inverts status bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command code present this cycle |
| cmd_code | input | 8 | Command code |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be taken |
| rd_ofs | input | OFS_W | Bus byte offset of the read |
| rsp_valid | output | 1 | Response register holds data |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8*RD_BYTES | Response data |
| mem_addr | output | OFS_W | Array memory address |
| mem_rdata | input | 8*RD_BYTES | Array memory data, same cycle |

## Verification
The assertions assume the consumer obeys the response handshake, that `mem_rdata` follows `mem_addr` within the cycle, and that commands and reads do not share a cycle whose result the checks depend on. The stimulus sends a command or a read one at a time, drains each response after a random stall of zero to three cycles, and never raises a read request while a response is still waiting. Offsets are drawn both from the low table range and across the full offset space, so index wrap of the identification decode and the end of the query table are both reached.

// File: rtl/flash_query_pkg.sv
package flash_query_pkg;

  typedef enum logic [1:0] {
    MD_ARRAY = 2'd0,
    MD_ID    = 2'd1,
    MD_CFI   = 2'd2,
    MD_STAT  = 2'd3
  } qmode_e;

  // Mode selected by a command code; unknown codes keep the current mode.
  function automatic qmode_e cmd_decode(input logic [7:0] code, input qmode_e cur);
    case (code)
      8'h90:               return MD_ID;
      8'h98:               return MD_CFI;
      8'hA0, 8'h10, 8'h30: return MD_STAT;
      8'h00, 8'h80:        return MD_ARRAY;
      default:             return cur;
    endcase
  endfunction

  // Per-device query table content, computed.
  function automatic logic [7:0] cfi_rom_byte(input logic [7:0] i);
    case (i)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      8'h13:   return 8'h02;
      default: return i ^ 8'hA5;
    endcase
  endfunction

endpackage

// File: rtl/flash_query_index.sv
module flash_query_index #(
  parameter int OFS_W      = 16,
  parameter int BANK_BYTES = 4,
  parameter int SHIFT      = 3,
  parameter int NSUB       = 2
) (
  input  logic [OFS_W-1:0] ofs,
  output logic [OFS_W-1:0] idx [NSUB]
);
  for (genvar k = 0; k < NSUB; k++) begin : g_sub
    logic [OFS_W-1:0] sub_ofs;
    assign sub_ofs = ofs + OFS_W'(k * BANK_BYTES);
    assign idx[k]  = sub_ofs >> SHIFT;
  end
endmodule

// File: rtl/flash_query_lane.sv
module flash_query_lane
  import flash_query_pkg::*;
#(
  parameter int          OFS_W      = 16,
  parameter int          BANK_BYTES = 4,
  parameter int          DEV_BYTES  = 1,
  parameter int          MAX_BYTES  = 2,
  parameter int          CFI_LEN    = 64,
  parameter logic [15:0] MFR_CODE   = 16'h0001,
  parameter logic [15:0] DEV_CODE   = 16'h22A7,
  parameter logic [15:0] EXT_CODE2  = 16'h0A0B,
  parameter logic [15:0] EXT_CODE3  = 16'hFFFF
) (
  input  qmode_e                  mode,
  input  logic [OFS_W-1:0]        idx,
  input  logic [8*BANK_BYTES-1:0] arr_slice,
  output logic [8*BANK_BYTES-1:0] bank_data
);
  localparam int  NDEV      = BANK_BYTES / DEV_BYTES;
  localparam int  DW        = 8 * DEV_BYTES;
  localparam bit  NARROW    = (MAX_BYTES != DEV_BYTES);
  localparam bit  NARROW_OK = (DEV_BYTES == 1) && (BANK_BYTES <= 8);
  localparam bit  CFI_ZERO  = NARROW && !NARROW_OK;

  logic [63:0]   id_word;
  logic          id_to_arr;
  logic [63:0]   cfi_word;
  logic [7:0]    cfi_byte;
  logic [DW-1:0] dev_val;

  // Identification decode on the low index byte only.
  always_comb begin
    id_word   = 64'd0;
    id_to_arr = 1'b0;
    case (idx[7:0])
      8'h00: id_word = {48'd0, MFR_CODE};
      8'h01: id_word = {48'd0, DEV_CODE};
      8'h02: id_word = 64'd0;
      8'h0E: begin
        id_word   = {48'd0, EXT_CODE2};
        id_to_arr = (EXT_CODE2 == 16'hFFFF);
      end
      8'h0F: begin
        id_word   = {48'd0, EXT_CODE3};
        id_to_arr = (EXT_CODE3 == 16'hFFFF);
      end
      default: id_to_arr = 1'b1;
    endcase
  end

  // Query table lookup with end-of-table and narrowed-width handling.
  always_comb begin
    if (idx < OFS_W'(CFI_LEN) && !CFI_ZERO) cfi_byte = cfi_rom_byte(idx[7:0]);
    else                                    cfi_byte = 8'd0;
    cfi_word = {56'd0, cfi_byte};
  end

  always_comb begin
    if (mode == MD_CFI) dev_val = cfi_word[DW-1:0];
    else                dev_val = id_word[DW-1:0];
    if (mode != MD_CFI && id_to_arr) bank_data = arr_slice;
    else                             bank_data = {NDEV{dev_val}};
  end
endmodule

// File: rtl/flash_query_resp.sv
module flash_query_resp
  import flash_query_pkg::*;
#(
  parameter int          OFS_W         = 16,
  parameter int          BANK_BYTES    = 4,
  parameter int          DEV_BYTES     = 1,
  parameter int          MAX_DEV_BYTES = 2,
  parameter int          RD_BYTES      = 8,
  parameter int          CFI_LEN       = 64,
  parameter logic [15:0] MFR_CODE      = 16'h0001,
  parameter logic [15:0] DEV_CODE      = 16'h22A7,
  parameter logic [15:0] EXT_CODE2     = 16'h0A0B,
  parameter logic [15:0] EXT_CODE3     = 16'hFFFF,
  parameter logic [7:0]  STAT_INIT     = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [7:0]            cmd_code,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic [OFS_W-1:0]      rd_ofs,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [8*RD_BYTES-1:0] rsp_data,
  output logic [OFS_W-1:0]      mem_addr,
  input  logic [8*RD_BYTES-1:0] mem_rdata
);
  localparam int MAX_EFF = (MAX_DEV_BYTES == 0) ? DEV_BYTES : MAX_DEV_BYTES;
  localparam int SHIFT   = $clog2(BANK_BYTES) + $clog2(MAX_EFF) - $clog2(DEV_BYTES);
  localparam int NSUB    = RD_BYTES / BANK_BYTES;
  localparam int BW      = 8 * BANK_BYTES;
  localparam int RD_W    = 8 * RD_BYTES;

  qmode_e           mode_q;
  logic [7:0]       stat_q;
  logic             rd_acc;
  logic [OFS_W-1:0] idx [NSUB];
  logic [RD_W-1:0]  lane_cat;
  logic [RD_W-1:0]  nxt_data;

  assign rd_ready = !rsp_valid || rsp_ready;
  assign rd_acc   = rd_valid && rd_ready;
  assign mem_addr = rd_ofs;

  flash_query_index #(
    .OFS_W(OFS_W), .BANK_BYTES(BANK_BYTES), .SHIFT(SHIFT), .NSUB(NSUB)
  ) u_index (
    .ofs(rd_ofs),
    .idx(idx)
  );

  for (genvar k = 0; k < NSUB; k++) begin : g_lane
    flash_query_lane #(
      .OFS_W(OFS_W), .BANK_BYTES(BANK_BYTES), .DEV_BYTES(DEV_BYTES),
      .MAX_BYTES(MAX_EFF), .CFI_LEN(CFI_LEN), .MFR_CODE(MFR_CODE),
      .DEV_CODE(DEV_CODE), .EXT_CODE2(EXT_CODE2), .EXT_CODE3(EXT_CODE3)
    ) u_lane (
      .mode(mode_q),
      .idx(idx[k]),
      .arr_slice(mem_rdata[k*BW +: BW]),
      .bank_data(lane_cat[k*BW +: BW])
    );
  end

  always_comb begin
    case (mode_q)
      MD_ARRAY: nxt_data = mem_rdata;
      MD_STAT:  nxt_data = {RD_BYTES{stat_q}};
      default:  nxt_data = lane_cat;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MD_ARRAY;
      stat_q    <= STAT_INIT;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (cmd_valid) mode_q <= cmd_decode(cmd_code, mode_q);
      if (rd_acc && mode_q == MD_STAT) stat_q <= stat_q ^ 8'h40;
      if (rd_acc) begin
        rsp_valid <= 1'b1;
        rsp_data  <= nxt_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_query_resp_chk.sv
module flash_query_resp_chk #(
  parameter int RD_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [7:0]      cmd_code,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [RD_W-1:0] rsp_data,
  input logic [1:0]      mode_q,
  input logic [7:0]      stat_q
);
  // R3
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R3
  rsp_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);

  // R3
  no_stall_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !rd_ready);

  // R2
  cfi_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 8'h98) |=> (mode_q == 2'd2));

  // R2
  id_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 8'h90) |=> (mode_q == 2'd1));

  // R10
  stat_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && mode_q == 2'd3 && !cmd_valid) |=>
      (stat_q == ($past(stat_q) ^ 8'h40)));
endmodule

bind flash_query_resp flash_query_resp_chk #(.RD_W(RD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .mode_q(mode_q),
  .stat_q(stat_q)
);

// File: tb/test_flash_query_resp.sv
module test_flash_query_resp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [15:0] rd_ofs = 16'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_data;
  logic [15:0] mem_addr;
  logic [63:0] mem_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int         m_mode = 0;   // 0 array, 1 id, 2 cfi, 3 status
  logic [7:0] m_stat = 8'h80;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] mem_model(input logic [15:0] a);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = (a[7:0] + 8'(i*37)) ^ a[15:8];
    return r;
  endfunction

  assign mem_rdata = mem_model(mem_addr);

  flash_query_resp i_flash_query_resp (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_ofs(rd_ofs),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] tbl(input int i);
    if (i >= 64) return 8'h00;
    case (i)
      16: return 8'h51;
      17: return 8'h52;
      18: return 8'h59;
      19: return 8'h02;
      default: return 8'(i) ^ 8'hA5;
    endcase
  endfunction

  function automatic logic [63:0] exp_rsp(input int md, input logic [15:0] ofs,
                                          input logic [7:0] st);
    logic [63:0] r;
    logic [63:0] arr;
    arr = mem_model(ofs);
    if (md == 0) return arr;
    if (md == 3) return {8{st}};
    for (int k = 0; k < 2; k++) begin
      logic [15:0] ix;
      logic [7:0]  b;
      bit          use_arr;
      ix = (ofs + 16'(4*k)) >> 3;
      use_arr = 1'b0;
      b = 8'h00;
      if (md == 2) b = tbl(int'(ix));
      else begin
        case (ix[7:0])
          8'h00: b = 8'h01;
          8'h01: b = 8'hA7;
          8'h02: b = 8'h00;
          8'h0E: b = 8'h0B;
          default: use_arr = 1'b1;
        endcase
      end
      r[32*k +: 32] = use_arr ? arr[32*k +: 32] : {4{b}};
    end
    return r;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    case (code)
      8'h90: m_mode = 1;
      8'h98: m_mode = 2;
      8'hA0, 8'h10, 8'h30: m_mode = 3;
      8'h00, 8'h80: m_mode = 0;
      default: ;
    endcase
  endtask

  task automatic do_read(input logic [15:0] ofs, input int stall, input string tag);
    logic [63:0] exp;
    @(negedge clk);
    rd_valid = 1'b1;
    rd_ofs   = ofs;
    exp = exp_rsp(m_mode, ofs, m_stat);
    if (m_mode == 0) check({48'd0, mem_addr}, {48'd0, ofs}, "R4 mem_addr");
    @(posedge clk);
    #1 rd_valid = 1'b0;
    if (m_mode == 3) m_stat = m_stat ^ 8'h40;
    @(negedge clk);
    check({63'd0, rsp_valid}, 64'd1, "R3 rsp_valid");
    check(rsp_data, exp, tag);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(rsp_data, exp, "R3 hold");
      check({63'd0, rd_ready}, 64'd0, "R3 rd_ready stall");
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
  endtask

  function automatic string mode_tag(input int md);
    case (md)
      0: return "R4 array";
      1: return "R6 R7 id";
      2: return "R8 cfi";
      default: return "R10 status";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({63'd0, rsp_valid}, 64'd0, "R1 rsp_valid");
    check({63'd0, rd_ready}, 64'd1, "R1 rd_ready");
    do_read(16'h0123, 0, "R1 array after reset");
    do_cmd(8'h30);
    do_read(16'h0000, 1, "R1 R10 status init");
    do_read(16'h0000, 0, "R10 status toggled");
    do_read(16'h0000, 2, "R10 status back");
    // R6 identification codes
    do_cmd(8'h90);
    do_read(16'h0000, 0, "R6 mfr");
    do_read(16'h0008, 0, "R6 dev code");
    do_read(16'h0010, 0, "R6 zero");
    do_read(16'h0800, 0, "R6 low byte decode");
    // R7 extended words and fallback
    do_read(16'h0074, 1, "R7 ext2 and ext3 fallback");
    do_read(16'h0040, 0, "R7 other index");
    // R8 R9 query table
    do_cmd(8'h98);
    do_read(16'h0080, 0, "R8 Q");
    do_read(16'h0088, 0, "R5 split index");
    do_read(16'h008C, 0, "R5 crossing part");
    do_read(16'h01FC, 0, "R8 table end");
    do_read(16'h0200, 0, "R8 past end");
    do_read(16'h0098, 0, "R9 byte repeated");
    // R2 unknown code leaves mode
    do_cmd(8'h55);
    do_read(16'h0090, 0, "R2 ignored code");
    do_cmd(8'hA0);
    do_read(16'h0000, 0, "R2 status A0");
    do_cmd(8'h10);
    do_read(16'h0000, 0, "R2 status 10");
    do_cmd(8'h80);
    do_read(16'h4321, 3, "R2 array 80");
    do_cmd(8'h00);
    do_read(16'hFFF8, 0, "R4 array 00");
    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = int'($urandom_range(0, 3));
      if (sel == 0) begin
        logic [7:0] codes [8];
        codes = '{8'h90, 8'h98, 8'hA0, 8'h10, 8'h30, 8'h00, 8'h80, 8'h00};
        codes[7] = 8'($urandom);
        do_cmd(codes[$urandom_range(0, 7)]);
      end else begin
        logic [15:0] o;
        o = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 16'h03FF)) : 16'($urandom);
        do_read(o, int'($urandom_range(0, 3)), mode_tag(m_mode));
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule